// File: doc/BRIEF.md
# Multichannel Pulse Interval Timer

The block watches sixteen asynchronous pulse lines and, for each of them, measures two things at once: how long a start pulse stays high, and how long it takes from the rising edge of that start pulse until the rising edge of a later, much shorter pulse. Time is counted in cycles of a 100 MHz sample clock, so one count is 10 ns. All channels have their own synchroniser, counters and state machine. None of them waits on another, so channels that see identical timing in the same frame report identical results.

The start pulse width carries a 3-bit value. A width below a programmable minimum is not treated as a start pulse at all. A qualifying width is compared against eight programmable inclusive ranges. The lowest-numbered range that contains the width gives the code. A width that falls in no range still starts an interval measurement, but the result is flagged as a bad code. If no second pulse arrives before the interval count reaches a programmable limit, the channel records a timeout and becomes ready for a new start pulse. A typical limit is 840,000 counts, which is 8.4 ms.

Each channel keeps its latest result. A frame strobe, typically at 60 Hz, copies every channel's latest result into a holding bank in the same cycle. A host then reads the holding bank one channel at a time through an index and a read strobe.

Top module: `pulse_interval_timer`

## Requirements
- R1: A start pulse whose high time, counted in sampled clock cycles, is below `cfg_min_width` produces no result. The channel stays ready, so a qualifying start pulse that follows is measured normally.
- R2: For a qualifying start pulse of width W, the result code is the lowest index k (0 to 7) for which `lo[k] <= W <= hi[k]`, with both bounds inclusive. Bin k occupies bits [16k+15:16k] of `cfg_bin_lo` and `cfg_bin_hi`. The status is 0, meaning OK.
- R3: A qualifying width that lies in no bin yields status 1 (bad code) and code 0. The interval is still measured.
- R4: The reported interval is the number of clock cycles from the rising edge of the start pulse to the rising edge of the second pulse, as a 20-bit count.
- R5: If the interval count reaches `cfg_timeout` without a second rising edge, the result has status 2 (timeout), the decoded code, and an interval equal to `cfg_timeout`. The channel then re-arms.
- R6: All channels measure concurrently and independently. Identical stimulus on several channels gives identical results.
- R7: A `frame_tick` copies each channel's latest result into the holding bank. The valid bit is 1 only for a channel that produced a result since the previous tick; otherwise it is 0.
- R8: A read with `rd_en` presents the holding entry of channel `rd_ch` on the `rd_*` outputs at the next clock edge. The read clears only that entry's valid bit, so a repeated read before the next tick shows valid 0 with the other fields unchanged.
- R9: If a channel produces a second result before a tick has collected the first, the newest result is kept and its overrun bit is 1. A result produced after a tick has overrun 0.
- R10: After reset all `rd_*` outputs are 0 and every holding entry reads as invalid with zero fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 100 MHz sample clock |
| rst | input | 1 | Synchronous active-high reset |
| pulse_in | input | 16 | Asynchronous pulse lines, one per channel |
| frame_tick | input | 1 | One-cycle frame strobe that collects results |
| cfg_min_width | input | 16 | Minimum start pulse width in cycles |
| cfg_bin_lo | input | 128 | Eight inclusive lower width bounds, 16 bits each |
| cfg_bin_hi | input | 128 | Eight inclusive upper width bounds, 16 bits each |
| cfg_timeout | input | 20 | Interval count at which a channel times out |
| rd_en | input | 1 | Read strobe for the holding bank |
| rd_ch | input | 4 | Channel index to read |
| rd_valid | output | 1 | Entry holds a new result |
| rd_overrun | output | 1 | An unread result was replaced |
| rd_status | output | 2 | 0 OK, 1 bad code, 2 timeout |
| rd_code | output | 3 | Decoded start-width code |
| rd_interval | output | 20 | Start-to-second-pulse interval in cycles |

## Verification
The assertions check the following on every cycle:
- a busy channel's interval count never passes the timeout;
- a channel moves to waiting for the second pulse only with a width at or above the minimum;
- an accepted code's bin really contains the captured width;
- a timeout result carries the timeout value;
- holding valid bits rise only on a tick, and a read clears the entry it addressed.

The measured numbers themselves need the bench's scenarios to show them. These are the exact interval and width counts, the inclusive edges of the bins, the lowest-bin priority, identical results across channels, and overrun across consecutive frames. The bench checks each of these against values worked out from the stimulus.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int PIT_CNT_W  = 20;
  localparam int PIT_WID_W  = 16;
  localparam int PIT_CODE_W = 3;
  localparam int PIT_BINS   = 1 << PIT_CODE_W;

  typedef enum logic [1:0] {
    ST_OK      = 2'd0,
    ST_BADCODE = 2'd1,
    ST_TIMEOUT = 2'd2
  } res_status_e;
endpackage

// File: rtl/pit_edge_sync.sv
module pit_edge_sync (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise,
  output logic fall
);
  logic s1, s2, s3;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= din;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign rise = s2 & ~s3;
  assign fall = ~s2 & s3;

  // R4: a detected rising edge reflects a low-to-high step on the raw input
  a_r4_rise_tracks_input: assert property (@(posedge clk) disable iff (rst)
    rise |-> ($past(din, 2) && !$past(din, 3)));
endmodule

// File: rtl/pit_width_decode.sv
module pit_width_decode #(
  parameter int WID_W  = pit_pkg::PIT_WID_W,
  parameter int CODE_W = pit_pkg::PIT_CODE_W,
  localparam int BINS  = 1 << CODE_W
) (
  input  logic [WID_W-1:0]      width,
  input  logic [BINS*WID_W-1:0] bin_lo,
  input  logic [BINS*WID_W-1:0] bin_hi,
  output logic                  hit,
  output logic [CODE_W-1:0]     code
);
  // Scan from the top bin down so the lowest matching bin wins.
  always_comb begin
    hit  = 1'b0;
    code = '0;
    for (int k = BINS - 1; k >= 0; k--) begin
      if (width >= bin_lo[k*WID_W +: WID_W] && width <= bin_hi[k*WID_W +: WID_W]) begin
        hit  = 1'b1;
        code = CODE_W'(k);
      end
    end
  end
endmodule

// File: rtl/pit_channel.sv
module pit_channel #(
  parameter int CNT_W  = pit_pkg::PIT_CNT_W,
  parameter int WID_W  = pit_pkg::PIT_WID_W,
  parameter int CODE_W = pit_pkg::PIT_CODE_W,
  localparam int BINS  = 1 << CODE_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     rise,
  input  logic                     fall,
  input  logic [WID_W-1:0]         cfg_min_width,
  input  logic [BINS*WID_W-1:0]    cfg_bin_lo,
  input  logic [BINS*WID_W-1:0]    cfg_bin_hi,
  input  logic [CNT_W-1:0]         cfg_timeout,
  output logic                     res_stb,
  output pit_pkg::res_status_e     res_status,
  output logic [CODE_W-1:0]        res_code,
  output logic [CNT_W-1:0]         res_interval
);
  import pit_pkg::*;

  typedef enum logic [1:0] {CH_IDLE, CH_HIGH, CH_WAIT} ch_state_e;

  ch_state_e          state;
  logic [CNT_W-1:0]   icnt;
  logic [WID_W-1:0]   wcnt;
  logic [CODE_W-1:0]  code_q;
  logic               bad_q;
  logic               dec_hit;
  logic [CODE_W-1:0]  dec_code;

  pit_width_decode #(.WID_W(WID_W), .CODE_W(CODE_W)) u_dec (
    .width (wcnt),
    .bin_lo(cfg_bin_lo),
    .bin_hi(cfg_bin_hi),
    .hit   (dec_hit),
    .code  (dec_code)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= CH_IDLE;
      icnt         <= '0;
      wcnt         <= '0;
      code_q       <= '0;
      bad_q        <= 1'b0;
      res_stb      <= 1'b0;
      res_status   <= ST_OK;
      res_code     <= '0;
      res_interval <= '0;
    end else begin
      res_stb <= 1'b0;
      case (state)
        CH_IDLE: begin
          if (rise) begin
            state <= CH_HIGH;
            icnt  <= CNT_W'(1);
            wcnt  <= WID_W'(1);
          end
        end
        CH_HIGH: begin
          if (icnt == cfg_timeout) begin
            state        <= CH_IDLE;
            res_stb      <= 1'b1;
            res_status   <= ST_TIMEOUT;
            res_code     <= '0;
            res_interval <= icnt;
          end else begin
            icnt <= icnt + CNT_W'(1);
            if (fall) begin
              if (wcnt < cfg_min_width) begin
                state <= CH_IDLE;
              end else begin
                state  <= CH_WAIT;
                code_q <= dec_hit ? dec_code : '0;
                bad_q  <= !dec_hit;
              end
            end else if (wcnt != '1) begin
              wcnt <= wcnt + WID_W'(1);
            end
          end
        end
        CH_WAIT: begin
          if (rise) begin
            state        <= CH_IDLE;
            res_stb      <= 1'b1;
            res_status   <= bad_q ? ST_BADCODE : ST_OK;
            res_code     <= code_q;
            res_interval <= icnt;
          end else if (icnt == cfg_timeout) begin
            state        <= CH_IDLE;
            res_stb      <= 1'b1;
            res_status   <= ST_TIMEOUT;
            res_code     <= code_q;
            res_interval <= icnt;
          end else begin
            icnt <= icnt + CNT_W'(1);
          end
        end
        default: state <= CH_IDLE;
      endcase
    end
  end

  // R5: a busy channel never counts past the timeout
  a_r5_count_bounded: assert property (@(posedge clk) disable iff (rst)
    (state != CH_IDLE && cfg_timeout != '0 && $stable(cfg_timeout)) |-> icnt <= cfg_timeout);

  // R5: a timeout result reports the configured limit
  a_r5_timeout_value: assert property (@(posedge clk) disable iff (rst)
    (res_stb && res_status == ST_TIMEOUT && $stable(cfg_timeout)) |-> res_interval == cfg_timeout);

  // R1: only a start pulse at or above the minimum width reaches the wait state
  a_r1_min_width: assert property (@(posedge clk) disable iff (rst)
    (state == CH_WAIT && $past(state) == CH_HIGH && $stable(cfg_min_width))
      |-> $past(wcnt) >= cfg_min_width);

  // R2: an accepted code names a bin that contains the captured width
  a_r2_code_in_bin: assert property (@(posedge clk) disable iff (rst)
    (state == CH_WAIT && $past(state) == CH_HIGH && !bad_q
      && $stable(cfg_bin_lo) && $stable(cfg_bin_hi))
      |-> ($past(wcnt) >= cfg_bin_lo[int'(code_q)*WID_W +: WID_W]
        && $past(wcnt) <= cfg_bin_hi[int'(code_q)*WID_W +: WID_W]));
endmodule

// File: rtl/pulse_interval_timer.sv
module pulse_interval_timer #(
  parameter int NCH    = 16,
  parameter int CNT_W  = pit_pkg::PIT_CNT_W,
  parameter int WID_W  = pit_pkg::PIT_WID_W,
  parameter int CODE_W = pit_pkg::PIT_CODE_W,
  localparam int BINS  = 1 << CODE_W,
  localparam int CH_W  = $clog2(NCH)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NCH-1:0]        pulse_in,
  input  logic                  frame_tick,
  input  logic [WID_W-1:0]      cfg_min_width,
  input  logic [BINS*WID_W-1:0] cfg_bin_lo,
  input  logic [BINS*WID_W-1:0] cfg_bin_hi,
  input  logic [CNT_W-1:0]      cfg_timeout,
  input  logic                  rd_en,
  input  logic [CH_W-1:0]       rd_ch,
  output logic                  rd_valid,
  output logic                  rd_overrun,
  output logic [1:0]            rd_status,
  output logic [CODE_W-1:0]     rd_code,
  output logic [CNT_W-1:0]      rd_interval
);
  import pit_pkg::*;

  logic [NCH-1:0]    ch_rise, ch_fall, ch_stb;
  res_status_e       ch_status   [NCH];
  logic [CODE_W-1:0] ch_code     [NCH];
  logic [CNT_W-1:0]  ch_interval [NCH];

  // latest result per channel
  logic [NCH-1:0]    lat_fresh, lat_ovr;
  res_status_e       lat_status   [NCH];
  logic [CODE_W-1:0] lat_code     [NCH];
  logic [CNT_W-1:0]  lat_interval [NCH];

  // holding bank collected at frame ticks
  logic [NCH-1:0]    hold_valid, hold_ovr;
  res_status_e       hold_status   [NCH];
  logic [CODE_W-1:0] hold_code     [NCH];
  logic [CNT_W-1:0]  hold_interval [NCH];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    pit_edge_sync u_sync (
      .clk (clk),
      .rst (rst),
      .din (pulse_in[c]),
      .rise(ch_rise[c]),
      .fall(ch_fall[c])
    );

    pit_channel #(.CNT_W(CNT_W), .WID_W(WID_W), .CODE_W(CODE_W)) u_chan (
      .clk          (clk),
      .rst          (rst),
      .rise         (ch_rise[c]),
      .fall         (ch_fall[c]),
      .cfg_min_width(cfg_min_width),
      .cfg_bin_lo   (cfg_bin_lo),
      .cfg_bin_hi   (cfg_bin_hi),
      .cfg_timeout  (cfg_timeout),
      .res_stb      (ch_stb[c]),
      .res_status   (ch_status[c]),
      .res_code     (ch_code[c]),
      .res_interval (ch_interval[c])
    );

    // R7: a holding entry becomes valid only when a tick collects it
    a_r7_valid_on_tick: assert property (@(posedge clk) disable iff (rst)
      $rose(hold_valid[c]) |-> $past(frame_tick));

    // R9: a second result before collection marks the entry as overrun
    a_r9_overrun_set: assert property (@(posedge clk) disable iff (rst)
      (ch_stb[c] && lat_fresh[c] && !frame_tick) |=> lat_ovr[c]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_fresh  <= '0;
      lat_ovr    <= '0;
      hold_valid <= '0;
      hold_ovr   <= '0;
      for (int c = 0; c < NCH; c++) begin
        lat_status[c]    <= ST_OK;
        lat_code[c]      <= '0;
        lat_interval[c]  <= '0;
        hold_status[c]   <= ST_OK;
        hold_code[c]     <= '0;
        hold_interval[c] <= '0;
      end
    end else begin
      for (int c = 0; c < NCH; c++) begin
        if (ch_stb[c]) begin
          lat_fresh[c]    <= 1'b1;
          lat_ovr[c]      <= lat_fresh[c] && !frame_tick;
          lat_status[c]   <= ch_status[c];
          lat_code[c]     <= ch_code[c];
          lat_interval[c] <= ch_interval[c];
        end else if (frame_tick) begin
          lat_fresh[c] <= 1'b0;
          lat_ovr[c]   <= 1'b0;
        end

        if (frame_tick) begin
          hold_valid[c]    <= lat_fresh[c];
          hold_ovr[c]      <= lat_ovr[c];
          hold_status[c]   <= lat_status[c];
          hold_code[c]     <= lat_code[c];
          hold_interval[c] <= lat_interval[c];
        end else if (rd_en && rd_ch == CH_W'(c)) begin
          hold_valid[c] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid    <= 1'b0;
      rd_overrun  <= 1'b0;
      rd_status   <= 2'd0;
      rd_code     <= '0;
      rd_interval <= '0;
    end else if (rd_en) begin
      rd_valid    <= hold_valid[rd_ch];
      rd_overrun  <= hold_ovr[rd_ch];
      rd_status   <= hold_status[rd_ch];
      rd_code     <= hold_code[rd_ch];
      rd_interval <= hold_interval[rd_ch];
    end
  end

  // R8: a read without a tick clears the valid bit it addressed
  a_r8_read_clears: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !frame_tick) |=> !hold_valid[$past(rd_ch)]);
endmodule

// File: tb/pulse_interval_timer_bench.sv
`timescale 1ns/1ps
module pulse_interval_timer_bench;
  localparam int NCH = 16;
  localparam int CNT_W = 20;
  localparam int WID_W = 16;

  typedef struct packed {
    logic       v;
    logic       o;
    logic [1:0] s;
    logic [2:0] c;
    logic [19:0] i;
  } exp_t;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic               rst = 1'b1;
  logic [NCH-1:0]     pulse_in = '0;
  logic               frame_tick = 1'b0;
  logic [WID_W-1:0]   cfg_min_width = 16'd4;
  logic [8*WID_W-1:0] cfg_bin_lo, cfg_bin_hi;
  logic [CNT_W-1:0]   cfg_timeout = 20'd300;
  logic               rd_en = 1'b0;
  logic [3:0]         rd_ch = '0;
  logic               rd_valid, rd_overrun;
  logic [1:0]         rd_status;
  logic [2:0]         rd_code;
  logic [19:0]        rd_interval;

  int checks = 0;
  int failures = 0;
  exp_t  exp_q[$];
  string tag_q[$];
  logic  rd_fire = 1'b0;

  initial begin
    for (int k = 0; k < 8; k++) begin
      cfg_bin_lo[k*WID_W +: WID_W] = 16'(10 + 10*k);
      cfg_bin_hi[k*WID_W +: WID_W] = 16'(14 + 10*k);
    end
  end

  pulse_interval_timer u_pulse_interval_timer (
    .clk(clk), .rst(rst), .pulse_in(pulse_in), .frame_tick(frame_tick),
    .cfg_min_width(cfg_min_width), .cfg_bin_lo(cfg_bin_lo), .cfg_bin_hi(cfg_bin_hi),
    .cfg_timeout(cfg_timeout), .rd_en(rd_en), .rd_ch(rd_ch),
    .rd_valid(rd_valid), .rd_overrun(rd_overrun), .rd_status(rd_status),
    .rd_code(rd_code), .rd_interval(rd_interval)
  );

  // monitor: compares each registered read against the scoreboard
  always @(posedge clk) rd_fire <= rd_en;

  always @(negedge clk) begin
    if (rd_fire) begin
      exp_t  got, want;
      string tag;
      got = {rd_valid, rd_overrun, rd_status, rd_code, rd_interval};
      checks++;
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL scoreboard: unexpected read got=%h expected=<none>", got);
      end else begin
        want = exp_q.pop_front();
        tag  = tag_q.pop_front();
        if (got !== want) begin
          failures++;
          $display("FAIL %s: got v=%0b o=%0b s=%0d c=%0d i=%0d expected v=%0b o=%0b s=%0d c=%0d i=%0d",
                   tag, got.v, got.o, got.s, got.c, got.i, want.v, want.o, want.s, want.c, want.i);
        end
      end
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_pair(input logic [NCH-1:0] m, input int w, input int gap);
    @(negedge clk);
    pulse_in = pulse_in | m;
    wait_cyc(w);
    pulse_in = pulse_in & ~m;
    wait_cyc(gap - w);
    pulse_in = pulse_in | m;
    wait_cyc(3);
    pulse_in = pulse_in & ~m;
    wait_cyc(10);
  endtask

  task automatic start_only(input logic [NCH-1:0] m, input int w);
    @(negedge clk);
    pulse_in = pulse_in | m;
    wait_cyc(w);
    pulse_in = pulse_in & ~m;
  endtask

  task automatic tick();
    @(negedge clk);
    frame_tick = 1'b1;
    @(negedge clk);
    frame_tick = 1'b0;
  endtask

  // driver: pushes the expected item, then issues the read
  task automatic read_expect(input int ch, input logic v, input logic o, input logic [1:0] s,
                             input logic [2:0] c, input int i, input string tag);
    exp_t e;
    e = {v, o, s, c, 20'(i)};
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    rd_ch = 4'(ch);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    failures++;
    $display("FAIL watchdog: run did not complete, got=hung expected=done");
    finish_run();
  end

  initial begin
    wait_cyc(5);
    rst = 1'b0;
    wait_cyc(2);
    // R10: registered read outputs are cleared by reset
    checks++;
    if ({rd_valid, rd_overrun, rd_status, rd_code, rd_interval} !== '0) begin
      failures++;
      $display("FAIL R10: rd outputs got=%h expected=0",
               {rd_valid, rd_overrun, rd_status, rd_code, rd_interval});
    end
    read_expect(0, 0, 0, 0, 0, 0, "R10 holding empty after reset");

    // R6, R4, R2: identical timing on three channels at once
    pulse_pair(16'h8021, 30, 100);
    tick();
    read_expect(0,  1, 0, 0, 2, 100, "R6 ch0 identical timing");
    read_expect(5,  1, 0, 0, 2, 100, "R4 ch5 interval");
    read_expect(15, 1, 0, 0, 2, 100, "R2 ch15 code");
    read_expect(3,  0, 0, 0, 0, 0,   "R7 idle channel invalid");
    read_expect(5,  0, 0, 0, 2, 100, "R8 reread clears valid only");

    // R1: narrow pulse ignored, channel stays armed
    start_only(16'h0002, 2);
    wait_cyc(10);
    tick();
    read_expect(1, 0, 0, 0, 0, 0, "R1 narrow pulse ignored");
    pulse_pair(16'h0002, 50, 200);
    tick();
    read_expect(1, 1, 0, 0, 4, 200, "R1 armed after narrow pulse");

    // R3: width outside all bins
    pulse_pair(16'h0004, 16, 120);
    // R5: timeout after a code-7 start pulse
    start_only(16'h0010, 80);
    wait_cyc(330);
    tick();
    read_expect(2, 1, 0, 1, 0, 120, "R3 bad code");
    read_expect(4, 1, 0, 2, 7, 300, "R5 timeout");
    pulse_pair(16'h0010, 40, 90);
    tick();
    read_expect(4, 1, 0, 0, 3, 90, "R5 re-armed after timeout");

    // R9: two results in one frame, then one
    pulse_pair(16'h0040, 10, 40);
    pulse_pair(16'h0040, 20, 60);
    tick();
    read_expect(6, 1, 1, 0, 1, 60, "R9 overrun keeps newest");
    pulse_pair(16'h0040, 30, 70);
    tick();
    read_expect(6, 1, 0, 0, 2, 70, "R9 overrun clears next frame");

    // R2 bin edges and R3 at the minimum width
    pulse_pair(16'h0080, 14, 50);
    pulse_pair(16'h0100, 20, 50);
    pulse_pair(16'h0200, 4, 50);
    pulse_pair(16'h0400, 3, 50);
    tick();
    read_expect(7,  1, 0, 0, 0, 50, "R2 upper bound inclusive");
    read_expect(8,  1, 0, 0, 1, 50, "R2 lower bound inclusive");
    read_expect(9,  1, 0, 1, 0, 50, "R3 minimum width no bin");
    read_expect(10, 0, 0, 0, 0, 0,  "R1 below minimum ignored");

    wait_cyc(5);
    if (exp_q.size() != 0) begin
      checks++;
      failures++;
      $display("FAIL scoreboard: pending got=%0d expected=0", exp_q.size());
    end
    finish_run();
  end
endmodule